// File: doc/BRIEF.md
# Cross-Domain Event Pulse Synchronizer

This block moves single-cycle event strobes from a source clock domain into an unrelated destination clock domain. Each strobe sampled high on a source clock edge becomes exactly one destination-cycle strobe on the far side. A strobe does not widen into a level, and it is never repeated. The source side holds a single state bit that flips once per accepted event. That bit crosses the boundary through a chain of destination-clocked flip-flops. On the far side, an edge detector turns each change of the resynchronized bit back into a one-cycle strobe.

Any ratio between the two clock frequencies is allowed, but the rate at which events can be accepted depends on that ratio. When the destination runs faster than the source, the input may stay high on every source cycle. When the source runs n times faster than the destination, accepted strobes must be spaced at least n source cycles apart, or events merge and are lost. The `STAGES` parameter sets the depth of the resynchronizing chain. A deeper chain adds latency. Values below two are raised to two.

Top module: `pulse_xing`

## Requirements
- R1: A strobe that is sampled high on one source clock edge, and is isolated from other strobes, produces exactly one destination cycle with `dst_pulse` high.
- R2: When the destination clock is faster than the source clock, `src_pulse` may be held high for any number of consecutive source cycles. The number of destination cycles with `dst_pulse` high then equals the number of source edges that sampled `src_pulse` high.
- R3: When the source clock is n times faster than the destination clock, strobes spaced n or more source cycles apart are all delivered. The count of `dst_pulse` high cycles then equals the count of strobes.
- R4: `dst_pulse` goes high right after the `STAGES`-th rising edge of `dst_clk` that follows the source edge which sampled the strobe. It is low before that edge.
- R5: Without input strobes, `dst_pulse` stays low.
- R6: `dst_pulse` is low while `dst_rst_n` is low and on the first destination cycle after reset is released. Both reset inputs are active low and assert asynchronously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low, asynchronous assert |
| src_pulse | input | 1 | Event strobe, sampled on rising `src_clk` |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low, asynchronous assert |
| dst_pulse | output | 1 | Regenerated one-cycle event strobe in the destination domain |

## Verification
The assertions assume three things about the inputs. Both domains are reset together before the first strobe. Each reset is released on the clock of its own domain. Strobes keep to the spacing that the clock ratio permits. The stimulus meets this as follows: it releases both resets while the input is idle, and it derives the strobe spacing from the period ratio of each run, either at the minimum n or with margin. It holds the input high continuously only when the destination clock is the faster one. The width check assumes that toggle changes are at least two destination periods apart, so it is applied only to runs whose timing guarantees that separation.

// File: rtl/pulse_xing_pkg.sv
package pulse_xing_pkg;
  // Fewest resynchronizing flops accepted in the crossing chain
  localparam int unsigned PX_MIN_STAGES = 2;

  // Value both sides of the crossing take in reset
  localparam logic PX_IDLE_LEVEL = 1'b0;

  function automatic int unsigned px_clamp_stages(input int unsigned req);
    return (req < PX_MIN_STAGES) ? PX_MIN_STAGES : req;
  endfunction
endpackage

// File: rtl/px_src_toggle.sv
module px_src_toggle
  import pulse_xing_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  output logic level_o
);
  logic tog_q;
  logic tog_d;
  logic tog_en;

  always_comb begin
    tog_en = pulse_i;
    tog_d  = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= PX_IDLE_LEVEL;
    end else if (tog_en) begin
      tog_q <= tog_d;
    end
  end

  assign level_o = tog_q;

  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_i |=> (level_o != $past(level_o))); // R1
  AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_i |=> $stable(level_o)); // R5
endmodule

// File: rtl/px_sync_chain.sv
module px_sync_chain
  import pulse_xing_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0] stg_q;
  logic [DEPTH-1:0] stg_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_comb stg_d[i] = async_i;
    end else begin : g_body
      always_comb stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q[i] <= PX_IDLE_LEVEL;
      end else begin
        stg_q[i] <= stg_d[i];
      end
    end
  end

  assign sync_o = stg_q[LAST];
endmodule

// File: rtl/px_edge_regen.sv
module px_edge_regen
  import pulse_xing_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic pulse_o
);
  logic prev_q;
  logic prev_d;

  always_comb prev_d = level_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= PX_IDLE_LEVEL;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign pulse_o = level_i ^ prev_q;
endmodule

// File: rtl/pulse_xing.sv
module pulse_xing
  import pulse_xing_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_pulse,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);
  localparam int unsigned CHAIN_DEPTH = px_clamp_stages(STAGES);

  logic src_level;
  logic sync_level;

  px_src_toggle u_toggle (
    .clk     (src_clk),
    .rst_n   (src_rst_n),
    .pulse_i (src_pulse),
    .level_o (src_level)
  );

  px_sync_chain #(
    .DEPTH (CHAIN_DEPTH)
  ) u_chain (
    .clk     (dst_clk),
    .rst_n   (dst_rst_n),
    .async_i (src_level),
    .sync_o  (sync_level)
  );

  px_edge_regen u_regen (
    .clk     (dst_clk),
    .rst_n   (dst_rst_n),
    .level_i (sync_level),
    .pulse_o (dst_pulse)
  );

  AST_OUT_NEEDS_SYNC_EDGE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_pulse |-> (sync_level != $past(sync_level))); // R5
  AST_QUIET_AT_RELEASE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    $rose(dst_rst_n) |-> !dst_pulse); // R6
endmodule

// File: tb/pulse_xing_bench.sv
`timescale 1ns/1ps
module pulse_xing_bench;
  localparam int unsigned STAGES   = 3;
  localparam real         DST_HALF = 2.5;

  logic src_clk   = 1'b0;
  logic dst_clk   = 1'b0;
  logic src_rst_n = 1'b0;
  logic dst_rst_n = 1'b0;
  logic src_pulse = 1'b0;
  logic dst_pulse;

  real src_half = 2.5;

  int  errors   = 0;
  int  checks   = 0;
  int  out_cnt  = 0;
  int  wide_cnt = 0;
  bit  last_hi  = 1'b0;
  bit  done     = 1'b0;

  pulse_xing #(.STAGES(STAGES)) u_pulse_xing (
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .src_pulse (src_pulse),
    .dst_clk   (dst_clk),
    .dst_rst_n (dst_rst_n),
    .dst_pulse (dst_pulse)
  );

  initial begin
    #1.31;
    forever #(src_half) src_clk = ~src_clk;
  end

  initial forever #(DST_HALF) dst_clk = ~dst_clk;

  // Mid-cycle observation: each high destination cycle counts as one event
  always @(negedge dst_clk) begin
    if (dst_pulse === 1'b1) begin
      out_cnt = out_cnt + 1;
      if (last_hi) wide_cnt = wide_cnt + 1;
    end
    last_hi = (dst_pulse === 1'b1);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input int count, input int spacing);
    for (int k = 0; k < count; k++) begin
      @(negedge src_clk) src_pulse = 1'b1;
      if (spacing > 1) begin
        @(negedge src_clk) src_pulse = 1'b0;
        repeat (spacing - 2) @(negedge src_clk);
      end
    end
    @(negedge src_clk) src_pulse = 1'b0;
  endtask

  task automatic run_count(input string req, input int count, input int spacing,
                           input bit chk_width);
    int base;
    int wbase;
    base  = out_cnt;
    wbase = wide_cnt;
    send(count, spacing);
    repeat (4 * STAGES + 30) @(negedge dst_clk);
    check((out_cnt - base) == count, req, "event count", out_cnt - base, count);
    if (chk_width)
      check((wide_cnt - wbase) == 0, "R1", "back-to-back high cycles",
            wide_cnt - wbase, 0);
  endtask

  initial begin
    int base;
    // R6: quiet while held in reset
    #12;
    check(dst_pulse === 1'b0, "R6", "output during reset", int'(dst_pulse), 0);
    @(negedge src_clk) src_rst_n = 1'b1;
    @(negedge dst_clk) dst_rst_n = 1'b1;
    @(negedge dst_clk);
    check(dst_pulse === 1'b0, "R6", "output after release", int'(dst_pulse), 0);

    // R5: idle input gives no events
    base = out_cnt;
    repeat (40) @(negedge dst_clk);
    check(out_cnt == base, "R5", "events while idle", out_cnt - base, 0);

    // R4: latency with equal periods and a fixed phase offset
    base = out_cnt;
    @(negedge src_clk) src_pulse = 1'b1;
    @(posedge src_clk);
    #0.1 src_pulse = 1'b0;
    repeat (STAGES - 1) @(posedge dst_clk);
    #1 check(dst_pulse === 1'b0, "R4", "early output", int'(dst_pulse), 0);
    @(posedge dst_clk);
    #1 check(dst_pulse === 1'b1, "R4", "output at chain depth", int'(dst_pulse), 1);
    @(posedge dst_clk);
    #1 check(dst_pulse === 1'b0, "R1", "output one cycle wide", int'(dst_pulse), 0);
    repeat (10) @(negedge dst_clk);
    check(out_cnt - base == 1, "R1", "single event count", out_cnt - base, 1);

    // R1: isolated strobes at equal periods
    run_count("R1", 20, 4, 1'b1);

    // R2: slow source (12 ns), input held high continuously
    src_half = 6.0;
    repeat (6) @(negedge src_clk);
    run_count("R2", 25, 1, 1'b1);

    // R2: source just slower than destination (7 ns), full duty
    src_half = 3.5;
    repeat (6) @(negedge src_clk);
    run_count("R2", 30, 1, 1'b0);

    // R3: fast source (1.7 ns), ratio under 3:1, spacing 4 and spacing 3
    src_half = 0.85;
    repeat (6) @(negedge src_clk);
    run_count("R3", 40, 4, 1'b0);
    run_count("R3", 40, 3, 1'b0);

    // R5: quiet again after all traffic drains
    base = out_cnt;
    repeat (60) @(negedge dst_clk);
    check(out_cnt == base, "R5", "events after traffic", out_cnt - base, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule